// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a memory-mapped watchdog. Software programs a reload value, enables the down-counter and must service it before it runs out. Running out once raises an interrupt and restarts the count from the reload value. Running out a second time while that interrupt is still uncleared pulses the reset output, but only when reset generation is enabled. Because a reset needs two full count periods, software programs half of the timeout it wants.

A guard register protects every other register against stray writes. Writes reach the configuration only after a fixed key has been written to the guard register. Any other value written there closes it again. Clearing the interrupt also restarts the counter, so one write services the watchdog.

The register port is a plain single-cycle strobe. A write with `bus_valid` high takes effect at that clock edge. Read data is a combinational view of the addressed register and has no side effects. The port never back-pressures, so no ready signal exists. Addresses are byte offsets and the two low bits are ignored. Register map: reload value 0x000, live count 0x004 (read-only), control 0x008, interrupt acknowledge 0x00C (write), interrupt status 0x014 (read-only), guard 0xC00.

Top module: `dual_stage_watchdog`

## Requirements
- R1: After reset the guard reads 1 (locked), control reads 0, reload value and live count read 0xFFFFFFFF, status reads 0, and both `irq_o` and `wdt_rst_o` are low.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and the guard then reads 0. Writing any other value there locks it, and the guard then reads 1.
- R3: While the block is locked, writes to any offset other than 0xC00 change nothing.
- R4: Control bit 0 enables counting and the interrupt output. Bit 1 enables reset generation. Bits 31:2 read as zero.
- R5: A write to offset 0x000 stores the reload value and loads it into the counter at the same edge.
- R6: When bit 0 of control goes from 0 to 1, the counter starts from the reload value. While enabled it decrements by one per cycle. While disabled it holds.
- R7: On the clock edge after the count reads 0 while enabled, an expiry occurs. The first expiry sets the pending bit and reloads the counter.
- R8: Status bit 0 shows the raw pending bit. `irq_o` is the pending bit ANDed with control bit 0.
- R9: A write to offset 0x00C with bit 0 set clears pending and reloads the counter. With bit 0 clear, the write has no effect.
- R10: An expiry while pending is set produces a one-cycle pulse on `wdt_rst_o`, in the cycle after that expiry edge, if control bit 1 is set. If control bit 1 is clear, no pulse is produced.
- R11: After a reset pulse, pending stays set until system reset, and acknowledge writes do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| irq_o | output | 1 | Interrupt, pending gated by enable |
| wdt_rst_o | output | 1 | Single-cycle reset request |

## Verification
Some properties are checked by assertions on every cycle:
- a disabled counter holds its value, and an enabled counter that is not reloaded drops by exactly one;
- a write to the reload register while locked leaves it unchanged;
- the reset pulse lasts one cycle and needs a pending interrupt beforehand;
- once tripped, pending stays set;
- the interrupt output never rises while the block is disabled.

Other behaviour only the bench scenarios show:
- the key sequence;
- the exact cycle of each expiry;
- the acknowledge that restarts the count;
- the absence of a pulse when reset generation is off.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFF_RELOAD = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_ACK    = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_GUARD  = 12'hC00;
  localparam logic [DATA_W-1:0] GUARD_KEY  = 32'h1ACC_E551;
endpackage

// File: rtl/dsw_regs.sv
module dsw_regs
  import dsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] cnt_value,
  input  logic              pending,
  output logic              run_en,
  output logic              trip_en,
  output logic              reload,
  output logic [DATA_W-1:0] reload_val,
  output logic              ack_clear
);
  localparam int WSEL = ADDR_W - 2;

  logic              locked_q, run_q, trip_q;
  logic [DATA_W-1:0] reload_q;
  logic [WSEL-1:0]   word;
  logic              hit_reload, hit_count, hit_ctrl, hit_ack, hit_stat, hit_guard;
  logic              wr, wr_open, start_edge;

  assign word       = bus_addr[ADDR_W-1:2];
  assign hit_reload = (word == OFF_RELOAD[ADDR_W-1:2]);
  assign hit_count  = (word == OFF_COUNT[ADDR_W-1:2]);
  assign hit_ctrl   = (word == OFF_CTRL[ADDR_W-1:2]);
  assign hit_ack    = (word == OFF_ACK[ADDR_W-1:2]);
  assign hit_stat   = (word == OFF_STAT[ADDR_W-1:2]);
  assign hit_guard  = (word == OFF_GUARD[ADDR_W-1:2]);

  assign wr         = bus_valid && bus_write;
  assign wr_open    = wr && !locked_q;
  assign start_edge = wr_open && hit_ctrl && bus_wdata[0] && !run_q;
  assign ack_clear  = wr_open && hit_ack && bus_wdata[0];
  assign reload     = (wr_open && hit_reload) || start_edge || ack_clear;
  assign reload_val = (wr_open && hit_reload) ? bus_wdata : reload_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      run_q    <= 1'b0;
      trip_q   <= 1'b0;
      reload_q <= '1;
    end else begin
      if (wr && hit_guard) locked_q <= (bus_wdata != GUARD_KEY);
      if (wr_open && hit_reload) reload_q <= bus_wdata;
      if (wr_open && hit_ctrl) begin
        run_q  <= bus_wdata[0];
        trip_q <= bus_wdata[1];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_reload)     bus_rdata = reload_q;
    else if (hit_count) bus_rdata = cnt_value;
    else if (hit_ctrl)  bus_rdata = {{(DATA_W-2){1'b0}}, trip_q, run_q};
    else if (hit_stat)  bus_rdata = {{(DATA_W-1){1'b0}}, pending};
    else if (hit_guard) bus_rdata = {{(DATA_W-1){1'b0}}, locked_q};
  end

  assign run_en  = run_q;
  assign trip_en = trip_q;

  assert_locked_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && locked_q && hit_reload) |=> $stable(reload_q));
endmodule

// File: rtl/dsw_counter.sv
module dsw_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_value,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = run_en && !reload && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '1;
    else if (reload) cnt_q <= reload_val;
    else if (expire) cnt_q <= reload_val;
    else if (run_en) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_value = cnt_q;

  assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !reload) |=> $stable(cnt_q));
  assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !reload && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dsw_alarm.sv
module dsw_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack_clear,
  input  logic trip_en,
  output logic pending,
  output logic wdt_rst
);
  logic pend_q, tripped_q, pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      tripped_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (ack_clear && !tripped_q) pend_q <= 1'b0;
      else if (expire) begin
        if (!pend_q) pend_q <= 1'b1;
        else if (trip_en && !tripped_q) begin
          pulse_q   <= 1'b1;
          tripped_q <= 1'b1;
        end
      end
    end
  end

  assign pending = pend_q;
  assign wdt_rst = pulse_q;

  assert_one_cycle_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  assert_pulse_after_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(pend_q));
  assert_sticky_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tripped_q |=> pend_q);
endmodule

// File: rtl/dual_stage_watchdog.sv
module dual_stage_watchdog
  import dsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  logic              run_en, trip_en, reload, ack_clear, expire, pending;
  logic [DATA_W-1:0] reload_val, cnt_value;

  dsw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_value(cnt_value), .pending(pending), .run_en(run_en), .trip_en(trip_en),
    .reload(reload), .reload_val(reload_val), .ack_clear(ack_clear)
  );

  dsw_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .reload(reload),
    .reload_val(reload_val), .cnt_value(cnt_value), .expire(expire)
  );

  dsw_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .expire(expire), .ack_clear(ack_clear),
    .trip_en(trip_en), .pending(pending), .wdt_rst(wdt_rst_o)
  );

  assign irq_o = pending && run_en;

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !reload) |=> !irq_o);
endmodule

// File: tb/dual_stage_watchdog_test.sv
module dual_stage_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, wdt_rst_o;
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dual_stage_watchdog uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'hC00, 32'h0,        32'h1,        4'd1},  // R1 guard locked
    '{1'b0, 12'h000, 32'h0,        32'hFFFFFFFF, 4'd1},  // R1 reload value
    '{1'b0, 12'h004, 32'h0,        32'hFFFFFFFF, 4'd1},  // R1 live count
    '{1'b0, 12'h008, 32'h0,        32'h0,        4'd1},  // R1 control
    '{1'b0, 12'h014, 32'h0,        32'h0,        4'd1},  // R1 status
    '{1'b1, 12'h000, 32'h5,        32'hFFFFFFFF, 4'd3},  // R3 locked reload write
    '{1'b1, 12'h008, 32'h3,        32'h0,        4'd3},  // R3 locked control write
    '{1'b1, 12'hC00, 32'h12345678, 32'h1,        4'd2},  // R2 wrong key
    '{1'b1, 12'hC00, 32'h1ACCE551, 32'h0,        4'd2},  // R2 right key
    '{1'b1, 12'h008, 32'hFFFFFFFE, 32'h2,        4'd4},  // R4 reserved bits
    '{1'b1, 12'h000, 32'h40,       32'h40,       4'd5},  // R5 reload stored
    '{1'b0, 12'h004, 32'h0,        32'h40,       4'd5},  // R5 count loaded at once
    '{1'b1, 12'h008, 32'h0,        32'h0,        4'd4}   // R4 control cleared
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int highs;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 rst", {31'b0, wdt_rst_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      rd(VECS[i].addr, v);
      check($sformatf("R%0d vec %0d", VECS[i].req, i), v, VECS[i].exp);
    end

    // R6: start from reload value, count down
    wr(12'h000, 32'd3);
    wr(12'h008, 32'h1);
    rd(12'h004, v); check("R6 start", v, 32'd3);
    @(negedge clk); rd(12'h004, v); check("R6 step", v, 32'd2);
    @(negedge clk); @(negedge clk);
    rd(12'h014, v); check("R7 no early expiry", v, 32'h0);
    @(negedge clk);
    rd(12'h014, v); check("R7 status set", v, 32'h1);
    rd(12'h004, v); check("R7 reloaded", v, 32'd3);
    check("R8 irq on", {31'b0, irq_o}, 32'h1);

    // R9: ack with bit0 clear has no effect, bit0 set clears
    wr(12'h00C, 32'h0);
    rd(12'h014, v); check("R9 ack bit0 clear ignored", v, 32'h1);
    wr(12'h00C, 32'h1);
    rd(12'h014, v); check("R9 ack clears", v, 32'h0);
    rd(12'h004, v); check("R9 ack reloads", v, 32'd3);
    wr(12'h008, 32'h0);
    rd(12'h004, v);
    @(negedge clk); @(negedge clk);
    begin
      logic [31:0] v2;
      rd(12'h004, v2); check("R6 hold while disabled", v2, v);
    end

    // R10: no pulse with reset generation off
    wr(12'h008, 32'h1);
    highs = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (wdt_rst_o) highs++;
    end
    check("R10 no pulse when off", highs, 0);
    rd(12'h014, v); check("R7 pending held", v, 32'h1);
    wr(12'h008, 32'h0);
    check("R8 irq gated", {31'b0, irq_o}, 32'h0);
    rd(12'h014, v); check("R8 raw status", v, 32'h1);

    // R10: pulse on second expiry with reset generation on
    wr(12'h008, 32'h3);
    repeat (3) @(negedge clk);
    check("R10 no pulse before expiry", {31'b0, wdt_rst_o}, 32'h0);
    @(negedge clk);
    check("R10 pulse", {31'b0, wdt_rst_o}, 32'h1);
    @(negedge clk);
    check("R10 single cycle", {31'b0, wdt_rst_o}, 32'h0);

    // R11: pending sticky after trip
    wr(12'h00C, 32'h1);
    rd(12'h014, v); check("R11 sticky", v, 32'h1);

    // R3 / R2: relock then ignored write
    wr(12'h008, 32'h0);
    wr(12'hC00, 32'h0);
    wr(12'h000, 32'h77);
    rd(12'h000, v); check("R3 relocked ignore", v, 32'd3);
    rd(12'hC00, v); check("R2 relock reads 1", v, 32'h1);

    // R1: system reset again
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    rd(12'h014, v); check("R1 pending cleared", v, 32'h0);
    rd(12'h000, v); check("R1 reload restored", v, 32'hFFFFFFFF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule